// File: doc/BRIEF.md
# Configurable Serial Shift Unit

This block moves bytes in and out of a chip over a serial line without fixing the protocol. An 8-bit shift register and an edge counter share one clock event. That event can come from one of three places: a software strobe, a timer compare pulse, or the external serial clock line. When the external line is used, a setting picks which of its edges samples the input. Software owns the framing. It loads the shift register directly, reads it back directly, and reloads the counter whenever it needs to. No holding buffer sits between software and the shift register.

Two line styles are supported. The three-wire style drives a push-pull data output. That output is retimed so that it changes on the edge opposite to the sampling edge. The two-wire style drives open-drain enables for the data and clock lines. It also watches the bus for start and stop conditions. Once a start condition or a completed byte has been seen, it holds the clock line low until software acknowledges the event. Address matching and protocol sequencing stay in software.

All inputs from pins pass through a synchroniser, and the unit runs from one system clock. A byte needs 16 counted edges, because both edges of the serial clock are counted.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, the shift register, the counter, the data output, both line enables and all three flags are 0.
- R2: clk_src_i selects the clock event: 0 is a software strobe, 1 is a timer pulse, 2 is the external line with sampling on its rising edge, and 3 is the external line with sampling on its falling edge. Events from unselected sources change nothing. For the internal sources, events alternate between sampling and driving, and a counter write makes the next event a sampling one.
- R3: Every clock event adds one to the counter. An event that finds the counter at 15 wraps it to 0 and sets ovf_flag_o, so 16 events complete one byte. A counter write loads cnt_i and takes precedence over an event in the same cycle.
- R4: On each sampling event the shift register moves one place toward its MSB, and the synchronised di_i enters at bit 0. After 8 bits the register holds the received byte, first bit in bit 7.
- R5: In three-wire mode, do_o takes the register MSB on each non-sampling event. A data write also loads do_o with bit 7 of the written value. As a result, the bits leave MSB first.
- R6: In two-wire mode, sda_oe_o is high exactly when the register MSB is 0. In every other mode, sda_oe_o stays low.
- R7: In two-wire mode only, a falling di_i while scl_i is high sets start_flag_o. Writing 1 on start_clr_i clears it. The same falling edge in three-wire mode leaves the flag at 0.
- R8: In two-wire mode only, a rising di_i while scl_i is high sets stop_flag_o. Writing 1 on stop_clr_i clears it.
- R9: In two-wire mode, scl_oe_o is high whenever start_flag_o or ovf_flag_o is set. In every other mode, scl_oe_o is low.
- R10: If a flag's set event and its clear strobe arrive in the same cycle, the flag ends up set.
- R11: mode_i selects the line style: 0 is off, 1 is three-wire, 2 is two-wire, and 3 behaves as off. When off, clock events neither count nor shift, and do_o and both enables stay low.
- R12: A data write puts data_i into the shift register, visible on shreg_o in the next cycle. This write takes precedence over a shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Line style: off, three-wire or two-wire |
| clk_src_i | input | 2 | Clock event source and sampling edge |
| sw_strobe_i | input | 1 | Software clock strobe, one cycle |
| timer_evt_i | input | 1 | Timer compare pulse, one cycle |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| di_i | input | 1 | Serial data input, also the two-wire data line |
| data_wr_i | input | 1 | Write data_i into the shift register |
| data_i | input | 8 | Value for the shift register |
| cnt_wr_i | input | 1 | Write cnt_i into the edge counter |
| cnt_i | input | 4 | Value for the edge counter |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| start_clr_i | input | 1 | Clear the start flag |
| stop_clr_i | input | 1 | Clear the stop flag |
| shreg_o | output | 8 | Shift register contents |
| cnt_o | output | 4 | Edge counter value |
| do_o | output | 1 | Retimed three-wire data output |
| sda_oe_o | output | 1 | Pull the data line low |
| scl_oe_o | output | 1 | Pull the clock line low |
| ovf_flag_o | output | 1 | Byte complete flag |
| start_flag_o | output | 1 | Start condition seen |
| stop_flag_o | output | 1 | Stop condition seen |

## Verification
Two pairs of functions can collide in one cycle.

- **Counter wrap against overflow acknowledge.** The counter wraps at 15 on a clock event, and that wrap sets the overflow flag. If software acknowledges the flag in the same cycle, the two meet. The bench loads the counter with 15 and raises a software strobe and the overflow clear on the same edge. The flag must read set and the counter must read 0 afterwards.
- **Clock line rising against data line changing.** In two-wire mode, the clock line may rise in the same cycle that the data line changes. Such a change must not be taken as a start or stop condition. The bench changes the data line only while the clock is low during byte transfers. It then checks that neither condition flag was raised across a full two-wire byte. Real conditions, made with the clock held high, must raise the flags.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_3W  = 2'd1,
    MODE_2W  = 2'd2,
    MODE_RSV = 2'd3
  } wire_mode_e;

  typedef enum logic [1:0] {
    SRC_SW       = 2'd0,
    SRC_TIMER    = 2'd1,
    SRC_EXT_RISE = 2'd2,
    SRC_EXT_FALL = 2'd3
  } clk_src_e;
endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ssu_edge_sel.sv
module ssu_edge_sel
  import ssu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] src_i,
  input  logic       sw_strobe_i,
  input  logic       timer_evt_i,
  input  logic       scl_s_i,
  input  logic       phase_clr_i,
  output logic       samp_o,
  output logic       drive_o
);
  clk_src_e src;
  logic     scl_p, ph;
  logic     rise, fall, int_evt;

  assign src = clk_src_e'(src_i);

  always_comb begin
    rise    = scl_s_i & ~scl_p;
    fall    = ~scl_s_i & scl_p;
    int_evt = 1'b0;
    samp_o  = 1'b0;
    drive_o = 1'b0;
    unique case (src)
      SRC_SW:       int_evt = sw_strobe_i;
      SRC_TIMER:    int_evt = timer_evt_i;
      default:      int_evt = 1'b0;
    endcase
    unique case (src)
      SRC_SW, SRC_TIMER: begin
        samp_o  = en_i & int_evt & ~ph;
        drive_o = en_i & int_evt & ph;
      end
      SRC_EXT_RISE: begin
        samp_o  = en_i & rise;
        drive_o = en_i & fall;
      end
      default: begin
        samp_o  = en_i & fall;
        drive_o = en_i & rise;
      end
    endcase
  end

  // internal sources emulate a two-phase clock: even events sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      ph    <= 1'b0;
    end else begin
      scl_p <= scl_s_i;
      if (phase_clr_i)             ph <= 1'b0;
      else if (en_i && int_evt)    ph <= ~ph;
    end
  end
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              drive_i,
  input  logic              di_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] shreg_o,
  output logic              do_o
);
  logic [DATA_W-1:0] shreg_q;
  logic              do_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      do_q    <= 1'b0;
    end else begin
      if (wr_i)        shreg_q <= wdata_i;
      else if (samp_i) shreg_q <= {shreg_q[DATA_W-2:0], di_i};
      // output latch moves on the edge opposite to sampling
      if (wr_i)         do_q <= wdata_i[DATA_W-1];
      else if (drive_i) do_q <= shreg_q[DATA_W-1];
    end
  end

  assign shreg_o = shreg_q;
  assign do_o    = do_q;
endmodule

// File: rtl/ssu_counter.sv
module ssu_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, wrap;

  assign wrap = evt_i & ~wr_i & (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_i)       cnt_q <= wdata_i;
      else if (evt_i) cnt_q <= cnt_q + 1'b1;
      if (wrap)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/ssu_cond_det.sv
module ssu_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic start_clr_i,
  input  logic stop_clr_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_p, sda_p, start_q, stop_q;
  logic scl_hi, start_set, stop_set;

  // clock must be high in both cycles so a simultaneous rise is not a condition
  assign scl_hi    = scl_s_i & scl_p;
  assign start_set = en_i & scl_hi & sda_p & ~sda_s_i;
  assign stop_set  = en_i & scl_hi & ~sda_p & sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      scl_p <= scl_s_i;
      sda_p <= sda_s_i;
      if (start_set)        start_q <= 1'b1;
      else if (start_clr_i) start_q <= 1'b0;
      if (stop_set)         stop_q  <= 1'b1;
      else if (stop_clr_i)  stop_q  <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign stop_o  = stop_q;
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2 * DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        clk_src_i,
  input  logic              sw_strobe_i,
  input  logic              timer_evt_i,
  input  logic              scl_i,
  input  logic              di_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_clr_i,
  input  logic              start_clr_i,
  input  logic              stop_clr_i,
  output logic [DATA_W-1:0] shreg_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              do_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              ovf_flag_o,
  output logic              start_flag_o,
  output logic              stop_flag_o
);
  wire_mode_e mode;
  logic       three_w, two_w, en;
  logic [1:0] pins_s;
  logic       scl_s, sda_s, samp, drive, do_q;

  assign mode    = wire_mode_e'(mode_i);
  assign three_w = (mode == MODE_3W);
  assign two_w   = (mode == MODE_2W);
  assign en      = three_w | two_w;

  ssu_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, di_i}),
    .q_o   (pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  ssu_edge_sel u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .src_i      (clk_src_i),
    .sw_strobe_i(sw_strobe_i),
    .timer_evt_i(timer_evt_i),
    .scl_s_i    (scl_s),
    .phase_clr_i(cnt_wr_i),
    .samp_o     (samp),
    .drive_o    (drive)
  );

  ssu_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .samp_i (samp),
    .drive_i(drive),
    .di_i   (sda_s),
    .wr_i   (data_wr_i),
    .wdata_i(data_i),
    .shreg_o(shreg_o),
    .do_o   (do_q)
  );

  ssu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (samp | drive),
    .wr_i     (cnt_wr_i),
    .wdata_i  (cnt_i),
    .ovf_clr_i(ovf_clr_i),
    .cnt_o    (cnt_o),
    .ovf_o    (ovf_flag_o)
  );

  ssu_cond_det u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (two_w),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .start_clr_i(start_clr_i),
    .stop_clr_i (stop_clr_i),
    .start_o    (start_flag_o),
    .stop_o     (stop_flag_o)
  );

  assign do_o     = three_w & do_q;
  assign sda_oe_o = two_w & ~shreg_o[DATA_W-1];
  assign scl_oe_o = two_w & (start_flag_o | ovf_flag_o);
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              data_wr_i,
  input logic              cnt_wr_i,
  input logic [DATA_W-1:0] shreg_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              sda_oe_o,
  input logic              scl_oe_o,
  input logic              ovf_flag_o,
  input logic              start_flag_o,
  input logic              stop_flag_o
);
  assert_ovf_at_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> ($past(cnt_o) == {CNT_W{1'b1}} && cnt_o == '0));

  assert_shift_counts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(shreg_o) && !$past(data_wr_i) && !$past(cnt_wr_i)) |-> (cnt_o != $past(cnt_o)));

  assert_sda_two_wire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd2) |-> !sda_oe_o);

  assert_start_two_wire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_flag_o) |-> ($past(mode_i) == 2'd2));

  assert_stop_two_wire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_flag_o) |-> ($past(mode_i) == 2'd2));

  assert_scl_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && (ovf_flag_o || start_flag_o)) |-> scl_oe_o);

  assert_scl_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd2) |-> !scl_oe_o);

  assert_off_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == 2'd0 || mode_i == 2'd3) && !cnt_wr_i) |=> $stable(cnt_o));
endmodule

bind serial_shift_unit ssu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .data_wr_i   (data_wr_i),
  .cnt_wr_i    (cnt_wr_i),
  .shreg_o     (shreg_o),
  .cnt_o       (cnt_o),
  .sda_oe_o    (sda_oe_o),
  .scl_oe_o    (scl_oe_o),
  .ovf_flag_o  (ovf_flag_o),
  .start_flag_o(start_flag_o),
  .stop_flag_o (stop_flag_o)
);

// File: tb/sim_serial_shift_unit.sv
module sim_serial_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {mode, src, byte to send, byte on di}
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd1, 2'd0, 8'hA5, 8'h3C},
    {2'd1, 2'd1, 8'h0F, 8'hC3},
    {2'd1, 2'd2, 8'h81, 8'h5A},
    {2'd1, 2'd3, 8'h6E, 8'h99},
    {2'd2, 2'd2, 8'hC4, 8'hE7},
    {2'd2, 2'd3, 8'h3B, 8'h18}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode = 2'd0, src = 2'd0;
  logic sw_strobe = 0, timer_evt = 0, sclk = 0, di = 1;
  logic data_wr = 0, cnt_wr = 0, ovf_clr = 0, start_clr = 0, stop_clr = 0;
  logic [7:0] data = '0;
  logic [3:0] cnt_in = '0;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic do_o, sda_oe, scl_oe, ovf, start_f, stop_f;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [1:0] vmode, vsrc;
  logic [7:0] vdat, vdi, got;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_shift_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .clk_src_i(src),
    .sw_strobe_i(sw_strobe), .timer_evt_i(timer_evt), .scl_i(sclk), .di_i(di),
    .data_wr_i(data_wr), .data_i(data), .cnt_wr_i(cnt_wr), .cnt_i(cnt_in),
    .ovf_clr_i(ovf_clr), .start_clr_i(start_clr), .stop_clr_i(stop_clr),
    .shreg_o(shreg), .cnt_o(cnt), .do_o(do_o), .sda_oe_o(sda_oe), .scl_oe_o(scl_oe),
    .ovf_flag_o(ovf), .start_flag_o(start_f), .stop_flag_o(stop_f)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_edge(logic [1:0] s);
    case (s)
      2'd0: begin sw_strobe = 1; step(1); sw_strobe = 0; step(1); end
      2'd1: begin timer_evt = 1; step(1); timer_evt = 0; step(1); end
      default: begin sclk = ~sclk; step(5); end
    endcase
  endtask

  task automatic write_data(logic [7:0] v);
    data = v; data_wr = 1; step(1); data_wr = 0;
  endtask

  task automatic write_cnt(logic [3:0] v);
    cnt_in = v; cnt_wr = 1; step(1); cnt_wr = 0;
  endtask

  task automatic clr_ovf();
    ovf_clr = 1; step(1); ovf_clr = 0;
  endtask

  function automatic logic line_bit();
    return (vmode == 2'd2) ? ~sda_oe : do_o;
  endfunction

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    chk("R1 shreg", shreg, 0);
    chk("R1 cnt", cnt, 0);
    chk("R1 outputs", {do_o, sda_oe, scl_oe}, 0);
    chk("R1 flags", {ovf, start_f, stop_f}, 0);

    // table-driven byte transfers
    for (int v = 0; v < NVEC; v++) begin
      {vmode, vsrc, vdat, vdi} = VEC[v];
      sclk = 0; di = 1; mode = vmode; src = vsrc; step(6);
      write_data(vdat);
      write_cnt(4'd0);
      clr_ovf();
      for (int k = 7; k >= 0; k--) begin
        di = vdi[k]; step(2);
        if (vsrc == 2'd3) begin
          one_edge(vsrc); got[k] = line_bit(); one_edge(vsrc);
        end else begin
          got[k] = line_bit(); one_edge(vsrc); one_edge(vsrc);
        end
      end
      chk("R4 received byte", shreg, vdi);
      chk("R3 counter wrapped", cnt, 0);
      chk("R3 overflow flag", ovf, 1);
      chk(vmode == 2'd2 ? "R6 sda sequence" : "R5 do sequence", got, vdat);
      chk("R9 scl hold after byte", scl_oe, vmode == 2'd2);
      chk("R7 R8 no condition during byte", {start_f, stop_f}, 0);
      clr_ovf();
      chk("R9 scl released", scl_oe, 0);
      di = 1; step(2);
    end

    // R11: off mode ignores clock events
    mode = 2'd0; src = 2'd0; step(2);
    write_data(8'h55); write_cnt(4'd3);
    for (int i = 0; i < 4; i++) one_edge(2'd0);
    chk("R11 count frozen", cnt, 3);
    chk("R11 shreg frozen", shreg, 8'h55);
    chk("R11 outputs low", {do_o, sda_oe, scl_oe}, 0);
    mode = 2'd3; one_edge(2'd0);
    chk("R11 reserved mode frozen", cnt, 3);

    // R2: unselected sources are ignored
    mode = 2'd1; src = 2'd1; write_cnt(4'd0);
    for (int i = 0; i < 3; i++) one_edge(2'd0);
    chk("R2 strobe ignored under timer", cnt, 0);
    for (int i = 0; i < 3; i++) one_edge(2'd1);
    chk("R2 timer counted", cnt, 3);
    one_edge(2'd2); one_edge(2'd2);
    chk("R2 external ignored under timer", cnt, 3);

    // R3 / R10: wrap and same-cycle clear
    src = 2'd0; write_cnt(4'd14);
    one_edge(2'd0);
    chk("R3 no flag before wrap", ovf, 0);
    one_edge(2'd0);
    chk("R3 flag at wrap", ovf, 1);
    clr_ovf();
    chk("R3 flag cleared", ovf, 0);
    write_cnt(4'd15);
    sw_strobe = 1; ovf_clr = 1; step(1); sw_strobe = 0; ovf_clr = 0;
    chk("R10 set beats clear", ovf, 1);
    chk("R10 counter wrapped", cnt, 0);
    clr_ovf();

    // R7 / R8 / R9: bus conditions in two-wire mode
    mode = 2'd2; src = 2'd0; sclk = 0; di = 1; step(6);
    sclk = 1; step(6);
    di = 0; step(6);
    chk("R7 start seen", start_f, 1);
    chk("R9 scl held on start", scl_oe, 1);
    chk("R8 no stop on start", stop_f, 0);
    start_clr = 1; step(1); start_clr = 0;
    chk("R7 start cleared", start_f, 0);
    chk("R9 scl released", scl_oe, 0);
    di = 1; step(6);
    chk("R8 stop seen", stop_f, 1);
    chk("R7 no start on stop", start_f, 0);
    stop_clr = 1; step(1); stop_clr = 0;
    chk("R8 stop cleared", stop_f, 0);
    sclk = 0; step(6);
    mode = 2'd1; sclk = 1; step(6);
    di = 0; step(6);
    chk("R7 start ignored in three-wire", start_f, 0);
    di = 1; step(6);
    chk("R8 stop ignored in three-wire", stop_f, 0);
    sclk = 0; step(6);

    // R12 / R5 / R6: direct writes
    write_data(8'h80);
    chk("R12 shreg written", shreg, 8'h80);
    chk("R5 do loaded on write", do_o, 1);
    write_data(8'h7F);
    chk("R5 do follows new msb", do_o, 0);
    mode = 2'd2; write_data(8'h96);
    chk("R12 shreg rewritten", shreg, 8'h96);
    chk("R6 sda released on msb 1", sda_oe, 0);
    write_data(8'h16);
    chk("R6 sda pulled on msb 0", sda_oe, 1);
    chk("R5 do low in two-wire", do_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule